// File: doc/BRIEF.md
# Packed Lane Compare, Min/Max and Unpack Unit

This unit operates on a 32-bit word that holds either four 8-bit lanes or two 16-bit lanes. It compares the lanes for equality, greater-than, less-or-equal and less-than, and writes each answer as a lane mask. It also selects the per-lane minimum or maximum, takes a per-lane absolute value that can saturate, and widens the two low bytes of a source word into two 16-bit lanes.

The instruction carries no width or sign field. The unit takes both from the register index of the operand. Indices 2 to 7 select signed bytes, 8 to 15 unsigned bytes, 16 to 23 signed halfwords and 24 to 29 unsigned halfwords. The datapath is purely combinational. A single output register gives the result a fixed latency of one clock, so the unit can drop into an execute stage.

The design has no control sequencing, so it has no state machine. It has two states, named here:
- RESET: while `rst_n` is low, both outputs are held at zero.
- RUN: every clock edge loads the outputs from the current inputs.

RESET moves to RUN on the first edge with `rst_n` high. Driving `rst_n` low again returns the unit to RESET.

Top module: `pk_cmp_unit`

## Requirements
- R1: The operand bank index `bank_idx_i` selects the lane format as follows:
  - 2 to 7: signed 8-bit lanes.
  - 8 to 15: unsigned 8-bit lanes.
  - 16 to 23: signed 16-bit lanes.
  - 24 to 29: unsigned 16-bit lanes.
  - Any other index (0, 1, 30, 31) gives a result of zero and `sat_o` = 0.
- R2: Outputs are registered. The result for the inputs present at a rising clock edge appears just after that edge and holds until the next edge. While `rst_n` is low, `result_o` and `sat_o` are zero.
- R3: The compare codes are equal (op 0), greater-than (op 1), less-or-equal (op 2) and less-than (op 3). Each sets every bit of a lane to 1 when the relation holds for that lane, and every bit to 0 when it does not.
- R4: Ordering comparisons treat lanes as two's-complement numbers in signed banks and as unsigned numbers in unsigned banks.
- R5: Op 4 writes the per-lane minimum and op 5 the per-lane maximum, each using the bank's signedness.
- R6: Op 6 in a signed bank writes each lane's magnitude. When `sat_mode_i` = 1, a lane holding the most negative value becomes the largest positive value and `sat_o` = 1. When `sat_mode_i` = 0, that lane is returned unchanged and `sat_o` = 0. `sat_o` is 0 for every other op and lane value.
- R7: Op 6 in an unsigned bank returns the source word unchanged with `sat_o` = 0.
- R8: Op 7 with a byte-bank source widens the bytes into halfwords:
  - Byte 0 goes to bits 15:0 and byte 1 goes to bits 31:16.
  - Each byte is sign-extended in the signed bank and zero-extended in the unsigned bank.
  - Bytes 2 and 3 are ignored.
  - Op 7 with a halfword-bank source gives zero.
- R9: `src_b_i` has no effect on ops 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Operation code (0 EQ, 1 GT, 2 LE, 3 LT, 4 MIN, 5 MAX, 6 ABS, 7 UNPACK) |
| sat_mode_i | input | 1 | Enables absolute-value saturation |
| bank_idx_i | input | 5 | Register index that selects lane width and signedness |
| src_a_i | input | 32 | First operand, and the source for ABS and UNPACK |
| src_b_i | input | 32 | Second operand |
| result_o | output | 32 | Registered result word |
| sat_o | output | 1 | Registered saturation flag |

## Verification
The assertions run on every cycle and check the following:
- Comparison results are always whole-lane masks.
- Comparing a word with itself always yields all ones.
- An invalid bank always gives zero.
- The saturation flag only rises after a saturating absolute value.
- A signed unpack always repeats each byte's sign across its halfword.

The actual lane values are shown only by the bench scenarios. These cover signed against unsigned orderings with the same bit patterns, min/max selection, the most-negative absolute-value case with saturation on and off, and the extension and byte placement of an unpack.

// File: rtl/pk_cmp_pkg.sv
package pk_cmp_pkg;

    typedef enum logic [2:0] {
        OP_EQ   = 3'd0,
        OP_GT   = 3'd1,
        OP_LE   = 3'd2,
        OP_LT   = 3'd3,
        OP_MIN  = 3'd4,
        OP_MAX  = 3'd5,
        OP_ABS  = 3'd6,
        OP_UNPK = 3'd7
    } pk_op_e;

    typedef struct packed {
        logic valid;
        logic wide;
        logic sgn;
    } bank_t;

    localparam int IDX_W       = 5;
    localparam int S8_FIRST    = 2;
    localparam int U8_FIRST    = 8;
    localparam int S16_FIRST   = 16;
    localparam int U16_FIRST   = 24;
    localparam int U16_LAST    = 29;
    localparam int BYTE_W      = 8;
    localparam int HALF_W      = 16;

endpackage

// File: rtl/pk_bank_decode.sv
module pk_bank_decode
    import pk_cmp_pkg::*;
(
    input  logic [IDX_W-1:0] idx_i,
    output bank_t            bank_o
);
    always_comb begin
        bank_o = '0;
        if (int'(idx_i) >= S8_FIRST && int'(idx_i) < U8_FIRST) begin
            bank_o = '{valid: 1'b1, wide: 1'b0, sgn: 1'b1};
        end else if (int'(idx_i) >= U8_FIRST && int'(idx_i) < S16_FIRST) begin
            bank_o = '{valid: 1'b1, wide: 1'b0, sgn: 1'b0};
        end else if (int'(idx_i) >= S16_FIRST && int'(idx_i) < U16_FIRST) begin
            bank_o = '{valid: 1'b1, wide: 1'b1, sgn: 1'b1};
        end else if (int'(idx_i) >= U16_FIRST && int'(idx_i) <= U16_LAST) begin
            bank_o = '{valid: 1'b1, wide: 1'b1, sgn: 1'b0};
        end
    end
endmodule

// File: rtl/pk_lane_alu.sv
module pk_lane_alu
    import pk_cmp_pkg::*;
#(
    parameter int W = 8
) (
    input  pk_op_e         op_i,
    input  logic           sgn_i,
    input  logic           sat_mode_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic [W-1:0]   res_o,
    output logic           sat_o
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

    logic eq;
    logic gt;
    logic [W-1:0] neg_a;

    always_comb begin
        eq    = (a_i == b_i);
        gt    = sgn_i ? ($signed(a_i) > $signed(b_i)) : (a_i > b_i);
        neg_a = W'(~a_i + 1'b1);
    end

    always_comb begin
        res_o = '0;
        sat_o = 1'b0;
        unique case (op_i)
            OP_EQ:   res_o = {W{eq}};
            OP_GT:   res_o = {W{gt}};
            OP_LE:   res_o = {W{~gt}};
            OP_LT:   res_o = {W{~gt & ~eq}};
            OP_MIN:  res_o = gt ? b_i : a_i;
            OP_MAX:  res_o = gt ? a_i : b_i;
            OP_ABS: begin
                if (sgn_i && a_i[W-1]) begin
                    if (a_i == MOST_NEG && sat_mode_i) begin
                        res_o = MOST_POS;
                        sat_o = 1'b1;
                    end else begin
                        res_o = neg_a;
                    end
                end else begin
                    res_o = a_i;
                end
            end
            OP_UNPK: res_o = '0;
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/pk_cmp_unit.sv
module pk_cmp_unit
    import pk_cmp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         op_i,
    input  logic               sat_mode_i,
    input  logic [IDX_W-1:0]   bank_idx_i,
    input  logic [DATA_W-1:0]  src_a_i,
    input  logic [DATA_W-1:0]  src_b_i,
    output logic [DATA_W-1:0]  result_o,
    output logic               sat_o
);
    localparam int L8  = DATA_W / BYTE_W;
    localparam int L16 = DATA_W / HALF_W;

    pk_op_e op;
    bank_t  bank;

    logic [DATA_W-1:0] res8;
    logic [DATA_W-1:0] res16;
    logic [L8-1:0]     sat8;
    logic [L16-1:0]    sat16;
    logic [DATA_W-1:0] unpk;
    logic [DATA_W-1:0] res_d;
    logic              sat_d;

    assign op = pk_op_e'(op_i);

    pk_bank_decode u_dec (
        .idx_i  (bank_idx_i),
        .bank_o (bank)
    );

    for (genvar g = 0; g < L8; g++) begin : g_byte
        pk_lane_alu #(.W(BYTE_W)) u_lane (
            .op_i       (op),
            .sgn_i      (bank.sgn),
            .sat_mode_i (sat_mode_i),
            .a_i        (src_a_i[g*BYTE_W +: BYTE_W]),
            .b_i        (src_b_i[g*BYTE_W +: BYTE_W]),
            .res_o      (res8[g*BYTE_W +: BYTE_W]),
            .sat_o      (sat8[g])
        );
    end

    for (genvar g = 0; g < L16; g++) begin : g_half
        pk_lane_alu #(.W(HALF_W)) u_lane (
            .op_i       (op),
            .sgn_i      (bank.sgn),
            .sat_mode_i (sat_mode_i),
            .a_i        (src_a_i[g*HALF_W +: HALF_W]),
            .b_i        (src_b_i[g*HALF_W +: HALF_W]),
            .res_o      (res16[g*HALF_W +: HALF_W]),
            .sat_o      (sat16[g])
        );
    end

    always_comb begin
        for (int i = 0; i < L16; i++) begin
            unpk[i*HALF_W +: HALF_W] = {{(HALF_W-BYTE_W){bank.sgn & src_a_i[i*BYTE_W + BYTE_W-1]}},
                                        src_a_i[i*BYTE_W +: BYTE_W]};
        end
    end

    always_comb begin
        res_d = '0;
        sat_d = 1'b0;
        if (bank.valid) begin
            if (op == OP_UNPK) begin
                res_d = bank.wide ? '0 : unpk;
            end else if (bank.wide) begin
                res_d = res16;
                sat_d = |sat16;
            end else begin
                res_d = res8;
                sat_d = |sat8;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            sat_o    <= 1'b0;
        end else begin
            result_o <= res_d;
            sat_o    <= sat_d;
        end
    end
endmodule

// File: rtl/pk_cmp_unit_chk.sv
module pk_cmp_unit_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        op_i,
    input logic              sat_mode_i,
    input logic [4:0]        bank_idx_i,
    input logic [DATA_W-1:0] src_a_i,
    input logic [DATA_W-1:0] src_b_i,
    input logic [DATA_W-1:0] result_o,
    input logic              sat_o
);
    logic in_s8, in_u8, in_s16, in_u16, any_bank;
    assign in_s8   = bank_idx_i >= 5'd2  && bank_idx_i <= 5'd7;
    assign in_u8   = bank_idx_i >= 5'd8  && bank_idx_i <= 5'd15;
    assign in_s16  = bank_idx_i >= 5'd16 && bank_idx_i <= 5'd23;
    assign in_u16  = bank_idx_i >= 5'd24 && bank_idx_i <= 5'd29;
    assign any_bank = in_s8 | in_u8 | in_s16 | in_u16;

    logic prev_cmp8, prev_cmp16, prev_bad, prev_same, prev_unpk_s8, prev_abs_sat;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_cmp8    <= 1'b0;
            prev_cmp16   <= 1'b0;
            prev_bad     <= 1'b0;
            prev_same    <= 1'b0;
            prev_unpk_s8 <= 1'b0;
            prev_abs_sat <= 1'b0;
        end else begin
            prev_cmp8    <= (op_i <= 3'd3) && (in_s8 | in_u8);
            prev_cmp16   <= (op_i <= 3'd3) && (in_s16 | in_u16);
            prev_bad     <= !any_bank;
            prev_same    <= (op_i == 3'd0) && any_bank && (src_a_i == src_b_i);
            prev_unpk_s8 <= (op_i == 3'd7) && in_s8;
            prev_abs_sat <= (op_i == 3'd6) && sat_mode_i && (in_s8 | in_s16);
        end
    end

    function automatic logic bytes_are_masks(input logic [DATA_W-1:0] w);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < DATA_W/8; i++)
            ok &= (w[i*8 +: 8] == 8'h00) || (w[i*8 +: 8] == 8'hFF);
        return ok;
    endfunction

    function automatic logic halves_are_masks(input logic [DATA_W-1:0] w);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < DATA_W/16; i++)
            ok &= (w[i*16 +: 16] == 16'h0000) || (w[i*16 +: 16] == 16'hFFFF);
        return ok;
    endfunction

    assert_byte_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        prev_cmp8 |-> bytes_are_masks(result_o));

    assert_half_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        prev_cmp16 |-> halves_are_masks(result_o));

    assert_equal_self_R3: assert property (@(posedge clk) disable iff (!rst_n)
        prev_same |-> (result_o == '1));

    assert_bad_bank_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        prev_bad |-> (result_o == '0 && !sat_o));

    assert_sat_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sat_o |-> prev_abs_sat);

    assert_unpack_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
        prev_unpk_s8 |-> (result_o[15:8] == {8{result_o[7]}} && result_o[31:24] == {8{result_o[23]}}));
endmodule

bind pk_cmp_unit pk_cmp_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_i       (op_i),
    .sat_mode_i (sat_mode_i),
    .bank_idx_i (bank_idx_i),
    .src_a_i    (src_a_i),
    .src_b_i    (src_b_i),
    .result_o   (result_o),
    .sat_o      (sat_o)
);

// File: tb/pk_cmp_unit_bench.sv
module pk_cmp_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 24;

    typedef struct packed {
        logic [2:0]  op;
        logic        sat;
        logic [4:0]  idx;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] exp;
        logic        exp_sat;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{3'd0, 1'b0, 5'd2,  32'h11223344, 32'h11FF3300, 32'hFF00FF00, 1'b0, 4'd3}, // R3 eq bytes
        '{3'd1, 1'b0, 5'd2,  32'h80017F05, 32'h7F028003, 32'h0000FFFF, 1'b0, 4'd4}, // R4 signed gt
        '{3'd1, 1'b0, 5'd8,  32'h80017F05, 32'h7F028003, 32'hFF0000FF, 1'b0, 4'd4}, // R4 unsigned gt
        '{3'd2, 1'b0, 5'd2,  32'h80017F05, 32'h7F028003, 32'hFFFF0000, 1'b0, 4'd3}, // R3 le
        '{3'd3, 1'b0, 5'd2,  32'h05050505, 32'h04050680, 32'h0000FF00, 1'b0, 4'd3}, // R3 lt signed
        '{3'd3, 1'b0, 5'd8,  32'h05050505, 32'h04050680, 32'h0000FFFF, 1'b0, 4'd4}, // R4 lt unsigned
        '{3'd0, 1'b0, 5'd16, 32'h12345678, 32'h12345679, 32'hFFFF0000, 1'b0, 4'd3}, // R3 eq halves
        '{3'd4, 1'b0, 5'd16, 32'h80000010, 32'h7FFF0020, 32'h80000010, 1'b0, 4'd5}, // R5 min s16
        '{3'd5, 1'b0, 5'd24, 32'h80000010, 32'h7FFF0020, 32'h80000020, 1'b0, 4'd5}, // R5 max u16
        '{3'd4, 1'b0, 5'd8,  32'h80FF0102, 32'h7F000201, 32'h7F000101, 1'b0, 4'd5}, // R5 min u8
        '{3'd5, 1'b0, 5'd2,  32'h80FF0102, 32'h7F000201, 32'h7F000202, 1'b0, 4'd5}, // R5 max s8
        '{3'd6, 1'b1, 5'd2,  32'h80FB0500, 32'hDEADBEEF, 32'h7F050500, 1'b1, 4'd6}, // R6 sat on
        '{3'd6, 1'b0, 5'd2,  32'h80FB0500, 32'hDEADBEEF, 32'h80050500, 1'b0, 4'd6}, // R6 sat off
        '{3'd6, 1'b1, 5'd16, 32'h8000FFFF, 32'h00000000, 32'h7FFF0001, 1'b1, 4'd6}, // R6 s16
        '{3'd6, 1'b1, 5'd2,  32'h01FF7F81, 32'h00000000, 32'h01017F7F, 1'b0, 4'd6}, // R6 no sat
        '{3'd6, 1'b1, 5'd24, 32'h8000FFFF, 32'h00000000, 32'h8000FFFF, 1'b0, 4'd7}, // R7 unsigned
        '{3'd6, 1'b1, 5'd8,  32'h80FF0102, 32'h12345678, 32'h80FF0102, 1'b0, 4'd7}, // R7 unsigned
        '{3'd7, 1'b0, 5'd2,  32'h1234807F, 32'h00000000, 32'hFF80007F, 1'b0, 4'd8}, // R8 sign ext
        '{3'd7, 1'b0, 5'd8,  32'h1234807F, 32'h00000000, 32'h0080007F, 1'b0, 4'd8}, // R8 zero ext
        '{3'd7, 1'b0, 5'd16, 32'h1234807F, 32'h00000000, 32'h00000000, 1'b0, 4'd8}, // R8 wide src
        '{3'd7, 1'b0, 5'd2,  32'h1234807F, 32'hFFFFFFFF, 32'hFF80007F, 1'b0, 4'd9}, // R9 b ignored
        '{3'd6, 1'b1, 5'd16, 32'h8000FFFF, 32'hFFFFFFFF, 32'h7FFF0001, 1'b1, 4'd9}, // R9 b ignored
        '{3'd0, 1'b0, 5'd0,  32'h00000001, 32'h00000001, 32'h00000000, 1'b0, 4'd1}, // R1 bank 0
        '{3'd5, 1'b0, 5'd30, 32'h12345678, 32'h00000000, 32'h00000000, 1'b0, 4'd1}  // R1 bank 30
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = '0;
    logic        sat_mode_i = 1'b0;
    logic [4:0]  bank_idx_i = '0;
    logic [31:0] src_a_i = '0;
    logic [31:0] src_b_i = '0;
    logic [31:0] result_o;
    logic        sat_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pk_cmp_unit u_pk_cmp_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_i       (op_i),
        .sat_mode_i (sat_mode_i),
        .bank_idx_i (bank_idx_i),
        .src_a_i    (src_a_i),
        .src_b_i    (src_b_i),
        .result_o   (result_o),
        .sat_o      (sat_o)
    );

    task automatic check(input string req, input logic [31:0] exp, input logic exp_sat);
        checks++;
        if (result_o !== exp || sat_o !== exp_sat) begin
            errors++;
            $display("FAIL %s: result=%h sat=%b expected result=%h sat=%b",
                     req, result_o, sat_o, exp, exp_sat);
        end
    endtask

    task automatic apply(input logic [2:0] op, input logic s, input logic [4:0] idx,
                         input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        op_i = op; sat_mode_i = s; bank_idx_i = idx; src_a_i = a; src_b_i = b;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset state, with live inputs present
        op_i = 3'd0; bank_idx_i = 5'd2; src_a_i = 32'h5; src_b_i = 32'h5;
        @(negedge clk);
        check("R2", 32'h0, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            string tag;
            apply(VEC[i].op, VEC[i].sat, VEC[i].idx, VEC[i].a, VEC[i].b);
            tag = $sformatf("R%0d vec %0d", VEC[i].req, i);
            check(tag, VEC[i].exp, VEC[i].exp_sat);
        end

        // R2: output holds until the next edge after inputs change
        apply(3'd6, 1'b1, 5'd2, 32'h80808080, 32'h0);
        check("R2", 32'h7F7F7F7F, 1'b1);
        op_i = 3'd0; bank_idx_i = 5'd0; #1;
        check("R2", 32'h7F7F7F7F, 1'b1);
        @(negedge clk);
        check("R2", 32'h00000000, 1'b0);

        // R1: bank boundaries 7/8, 15/16, 29/30, 1
        apply(3'd1, 1'b0, 5'd7,  32'h00000080, 32'h00000001);
        check("R1", 32'h00000000, 1'b0);
        apply(3'd1, 1'b0, 5'd15, 32'h00000080, 32'h00000001);
        check("R1", 32'h000000FF, 1'b0);
        apply(3'd1, 1'b0, 5'd23, 32'h00008000, 32'h00000001);
        check("R1", 32'h00000000, 1'b0);
        apply(3'd1, 1'b0, 5'd29, 32'h00008000, 32'h00000001);
        check("R1", 32'h0000FFFF, 1'b0);
        apply(3'd0, 1'b0, 5'd1,  32'h0, 32'h0);
        check("R1", 32'h00000000, 1'b0);

        // R2: reset asserted mid-run clears the outputs
        apply(3'd0, 1'b0, 5'd8, 32'h0, 32'h0);
        check("R2", 32'hFFFFFFFF, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R2", 32'h00000000, 1'b0);
        rst_n = 1'b1;

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule